// File: doc/BRIEF.md
# Software-Maintained Translation Entry Array

This block stores the entries of a 64-entry unified address-translation buffer whose contents are kept entirely by software. It does not translate addresses. It only holds the entries and gives software two ways to change them.

The first path is a load command. On a one-cycle pulse, three staging words are copied into a single entry: a tag word, a frame word and an attribute word. The entry is chosen by a replacement pointer. After each load the pointer advances, and it wraps to zero once it reaches a software-supplied boundary. Software may also overwrite the pointer directly.

The second path is a memory-mapped port. Each entry appears through three 32-bit views:
- a tag view (virtual page, address-space tag);
- a frame view (physical page, size, protection, caching, write-through, sharing);
- an attribute view (space attribute, timing control).

The valid and dirty bits appear in both the tag view and the frame view. Both views refer to the same two storage bits.

Every memory-mapped request receives a response one cycle later. Full-word accesses only are accepted, and writes require privileged mode. A rejected request raises an error flag, returns zero and changes nothing.

Top module: `tlb_entry_store`

## Requirements
- R1: After reset the replacement pointer is 0, no response is pending, and every entry reads with valid bit clear and dirty bit clear.
- R2: A load pulse writes the staging words into the entry at the current pointer. The tag word supplies the virtual page [31:10] and the address-space tag [7:0]; its bits 9:8 are ignored. The frame word supplies all frame fields plus valid (bit 11) and dirty (bit 5). The attribute word supplies bits [3:0].
- R3: After a load (with no pointer write in the same cycle), the pointer becomes pointer+1, or 0 when the pointer is already greater than or equal to the boundary input.
- R4: A pointer write sets the pointer to the written value on the next cycle and takes priority over the advance from a load in the same cycle. That load still uses the old pointer.
- R5: Tag view word layout: virtual page [31:10], dirty [9], valid [8], address-space tag [7:0]. Reads return the stored entry, and writes update all of these fields.
- R6: Frame view word layout: physical page [31:12], valid [11], size [10:9], protection [8:7], cacheable [6], dirty [5], write-through [4], share [3]. Bits [2:0] read as 0.
- R7: Attribute view word layout: timing control [3], space attribute [2:0]. Bits [31:4] read as 0.
- R8: Valid and dirty are one storage pair per entry. A write through the tag view or the frame view is visible through the other view.
- R9: Only size code 2'b10 (32-bit) is accepted. Any other size sets the error flag in the response, returns read data 0 and leaves storage unchanged.
- R10: A write with the privilege input low is rejected: the error flag is set and storage is unchanged. A read with the privilege input low is served normally.
- R11: Address bits [23:20] select the view: 0 is tag, 1 is frame, 2 is attribute, and any other value is rejected with the error flag. Address bits [13:8] select the entry.
- R12: Every request produces exactly one response cycle on the cycle after the request. In that cycle the response-valid output is high, and write responses carry read data 0. The response-valid output is low in cycles that follow no request.
- R13: When a load and an accepted memory-mapped write occur in the same cycle, the load is performed, the memory-mapped write is discarded, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_cmd | input | 1 | Load command pulse |
| pt_hi | input | 32 | Staging tag word |
| pt_lo | input | 32 | Staging frame word |
| pt_attr | input | 32 | Staging attribute word |
| repl_we | input | 1 | Replacement pointer write enable |
| repl_wval | input | 6 | Value written to the pointer |
| repl_bound | input | 6 | Replacement boundary |
| repl_ptr | output | 6 | Current replacement pointer |
| mm_req | input | 1 | Memory-mapped request |
| mm_we | input | 1 | Request is a write |
| mm_addr | input | 32 | Request address (view and entry fields) |
| mm_size | input | 2 | Access size code, 2'b10 = 32-bit |
| mm_priv | input | 1 | Requester is in privileged mode |
| mm_wdata | input | 32 | Write data |
| mm_rvalid | output | 1 | Response valid |
| mm_rdata | output | 32 | Read data |
| mm_err | output | 1 | Request rejected |

## Verification
Assertions watch the following on every cycle:
- the pointer's advance, wrap and override rules;
- the one-cycle response after each request;
- the error flag for narrow sizes and for unprivileged writes;
- the zero read data on rejected requests;
- the stability of the valid and dirty storage whenever no write is let through.

The bench's directed scenarios cover what a per-cycle property cannot:
- that each field lands in the right bit position of each view;
- that a write through one view shows up through the other;
- that rejected and discarded writes leave the addressed entry intact;
- that the entry loaded is the one the pointer named before it moved.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 8;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 20;
  localparam int SA_W   = 3;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [3:0] {
    VIEW_ADDR  = 4'h0,
    VIEW_DATA1 = 4'h1,
    VIEW_DATA2 = 4'h2
  } view_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
  } tag_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       sz;
    logic [1:0]       pr;
    logic             c;
    logic             wt;
    logic             sh;
  } dat1_t;

  typedef struct packed {
    logic            tc;
    logic [SA_W-1:0] sa;
  } dat2_t;

  function automatic tag_t word_to_tag(logic [31:0] w);
    tag_t t;
    t.vpn  = w[31:10];
    t.asid = w[7:0];
    return t;
  endfunction

  function automatic logic [31:0] tag_to_word(tag_t t, logic v, logic d);
    return {t.vpn, d, v, t.asid};
  endfunction

  function automatic dat1_t word_to_d1(logic [31:0] w);
    dat1_t x;
    x.ppn = w[31:12];
    x.sz  = w[10:9];
    x.pr  = w[8:7];
    x.c   = w[6];
    x.wt  = w[4];
    x.sh  = w[3];
    return x;
  endfunction

  function automatic logic [31:0] d1_to_word(dat1_t x, logic v, logic d);
    return {x.ppn, v, x.sz, x.pr, x.c, d, x.wt, x.sh, 3'b000};
  endfunction

  function automatic dat2_t word_to_d2(logic [31:0] w);
    dat2_t x;
    x.tc = w[3];
    x.sa = w[2:0];
    return x;
  endfunction

  function automatic logic [31:0] d2_to_word(dat2_t x);
    return {28'h0, x.tc, x.sa};
  endfunction
endpackage

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_val,
  input  logic [IDX_W-1:0] bound,
  output logic [IDX_W-1:0] cnt
);
  logic [IDX_W:0] inc;
  assign inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (sw_we) cnt <= sw_val;
    else if (ld)    cnt <= (inc > {1'b0, bound}) ? '0 : inc[IDX_W-1:0];
  end

  // R3: wrap once the boundary is reached
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (ld && !sw_we && (cnt >= bound)) |=> (cnt == '0));
  // R3: plain advance below the boundary
  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (ld && !sw_we && (cnt < bound)) |=> (cnt == IDX_W'($past(cnt) + 1'b1)));
  // R4: software write wins
  p_sw_r4: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (cnt == $past(sw_val)));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !sw_we) |=> $stable(cnt));
endmodule

// File: rtl/tlb_mm_decode.sv
module tlb_mm_decode
  import tlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  logic [31:0]      addr,
  input  logic [1:0]       size,
  input  logic             priv,
  input  logic             ld_busy,
  output logic [IDX_W-1:0] idx,
  output logic [3:0]       view,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             rvalid,
  output logic             err
);
  logic view_ok, acc_ok;

  assign idx     = addr[8 +: IDX_W];
  assign view    = addr[23:20];
  assign view_ok = (view == VIEW_ADDR) || (view == VIEW_DATA1) || (view == VIEW_DATA2);
  assign acc_ok  = req && (size == SIZE_WORD) && view_ok && (!we || priv);
  assign wr_ok   = acc_ok && we && !ld_busy;
  assign rd_ok   = acc_ok && !we;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= req;
      err    <= req && !acc_ok;
    end
  end

  p_size_r9: assert property (@(posedge clk) disable iff (rst)
    (req && size != SIZE_WORD) |=> err);
  p_user_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (req && we && !priv) |=> err);
  p_resp_r12: assert property (@(posedge clk) disable iff (rst)
    req |=> rvalid);
  p_noresp_r12: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rvalid);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [31:0]      stage_hi,
  input  logic [31:0]      stage_lo,
  input  logic [31:0]      stage_attr,
  input  logic             mm_we,
  input  logic [3:0]       mm_view,
  input  logic [IDX_W-1:0] mm_idx,
  input  logic [31:0]      mm_wdata,
  input  logic             rd_en,
  output logic [31:0]      rdata
);
  tag_t  tag_mem [ENTRIES];
  dat1_t d1_mem  [ENTRIES];
  dat2_t d2_mem  [ENTRIES];
  logic [ENTRIES-1:0] vbits, dbits;

  logic [IDX_W-1:0] wr_idx;
  logic tag_we, d1_we, d2_we;
  tag_t  tag_wd;
  dat1_t d1_wd;
  dat2_t d2_wd;

  always_comb begin
    wr_idx = ld_we ? ld_idx : mm_idx;
    tag_we = ld_we || (mm_we && mm_view == VIEW_ADDR);
    d1_we  = ld_we || (mm_we && mm_view == VIEW_DATA1);
    d2_we  = ld_we || (mm_we && mm_view == VIEW_DATA2);
    tag_wd = word_to_tag(ld_we ? stage_hi   : mm_wdata);
    d1_wd  = word_to_d1 (ld_we ? stage_lo   : mm_wdata);
    d2_wd  = word_to_d2 (ld_we ? stage_attr : mm_wdata);
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[wr_idx] <= tag_wd;
    if (d1_we)  d1_mem[wr_idx]  <= d1_wd;
    if (d2_we)  d2_mem[wr_idx]  <= d2_wd;
  end

  // Shared valid/dirty pair, reachable from two views
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
      dbits <= '0;
    end else if (ld_we) begin
      vbits[ld_idx] <= stage_lo[11];
      dbits[ld_idx] <= stage_lo[5];
    end else if (mm_we) begin
      case (mm_view)
        VIEW_ADDR: begin
          vbits[mm_idx] <= mm_wdata[8];
          dbits[mm_idx] <= mm_wdata[9];
        end
        VIEW_DATA1: begin
          vbits[mm_idx] <= mm_wdata[11];
          dbits[mm_idx] <= mm_wdata[5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata <= '0;
    else begin
      case (mm_view)
        VIEW_ADDR:  rdata <= tag_to_word(tag_mem[mm_idx], vbits[mm_idx], dbits[mm_idx]);
        VIEW_DATA1: rdata <= d1_to_word(d1_mem[mm_idx], vbits[mm_idx], dbits[mm_idx]);
        default:    rdata <= d2_to_word(d2_mem[mm_idx]);
      endcase
    end
  end

  // R9 / R13: shared bits move only when a write is let through
  p_vd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ld_we && !mm_we) |=> ($stable(vbits) && $stable(dbits)));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_cmd,
  input  logic [31:0]      pt_hi,
  input  logic [31:0]      pt_lo,
  input  logic [31:0]      pt_attr,
  input  logic             repl_we,
  input  logic [IDX_W-1:0] repl_wval,
  input  logic [IDX_W-1:0] repl_bound,
  output logic [IDX_W-1:0] repl_ptr,
  input  logic             mm_req,
  input  logic             mm_we,
  input  logic [31:0]      mm_addr,
  input  logic [1:0]       mm_size,
  input  logic             mm_priv,
  input  logic [31:0]      mm_wdata,
  output logic             mm_rvalid,
  output logic [31:0]      mm_rdata,
  output logic             mm_err
);
  logic [IDX_W-1:0] acc_idx;
  logic [3:0]       acc_view;
  logic             wr_ok, rd_ok;

  tlb_repl_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst(rst), .ld(ld_cmd), .sw_we(repl_we),
    .sw_val(repl_wval), .bound(repl_bound), .cnt(repl_ptr)
  );

  tlb_mm_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .req(mm_req), .we(mm_we), .addr(mm_addr),
    .size(mm_size), .priv(mm_priv), .ld_busy(ld_cmd),
    .idx(acc_idx), .view(acc_view), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .rvalid(mm_rvalid), .err(mm_err)
  );

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst),
    .ld_we(ld_cmd), .ld_idx(repl_ptr),
    .stage_hi(pt_hi), .stage_lo(pt_lo), .stage_attr(pt_attr),
    .mm_we(wr_ok), .mm_view(acc_view), .mm_idx(acc_idx), .mm_wdata(mm_wdata),
    .rd_en(rd_ok), .rdata(mm_rdata)
  );

  // R9: rejected requests return zero
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (mm_rvalid && mm_err) |-> (mm_rdata == 32'h0));
endmodule

// File: tb/tb_tlb_entry_store.sv
`timescale 1ns/1ps
module tb_tlb_entry_store;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_cmd = 1'b0;
  logic [31:0] pt_hi = '0, pt_lo = '0, pt_attr = '0;
  logic        repl_we = 1'b0;
  logic [5:0]  repl_wval = '0, repl_bound = 6'd63;
  logic [5:0]  repl_ptr;
  logic        mm_req = 1'b0, mm_we = 1'b0, mm_priv = 1'b1;
  logic [31:0] mm_addr = '0, mm_wdata = '0;
  logic [1:0]  mm_size = 2'b10;
  logic        mm_rvalid, mm_err;
  logic [31:0] mm_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] rd;
  logic er, rv;

  always #2 clk = ~clk;

  tlb_entry_store dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mka(logic [3:0] view, logic [5:0] idx);
    return {8'h0, view, 6'h0, idx, 8'h0};
  endfunction

  task automatic mm(input logic we, input logic [31:0] addr, input logic [1:0] size,
                    input logic priv, input logic [31:0] wd);
    @(negedge clk);
    mm_req = 1'b1; mm_we = we; mm_addr = addr; mm_size = size;
    mm_priv = priv; mm_wdata = wd;
    @(posedge clk); #1;
    rd = mm_rdata; er = mm_err; rv = mm_rvalid;
    @(negedge clk);
    mm_req = 1'b0; mm_we = 1'b0; mm_priv = 1'b1; mm_size = 2'b10;
  endtask

  task automatic do_load(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] at);
    @(negedge clk);
    ld_cmd = 1'b1; pt_hi = hi; pt_lo = lo; pt_attr = at;
    @(negedge clk);
    ld_cmd = 1'b0;
  endtask

  task automatic set_ptr(input logic [5:0] v);
    @(negedge clk);
    repl_we = 1'b1; repl_wval = v;
    @(negedge clk);
    repl_we = 1'b0;
  endtask

  localparam logic [31:0] L0_HI = {22'h2ABCD, 2'b00, 8'h5A};
  localparam logic [31:0] L0_LO = {20'hABCDE, 1'b1, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 3'b000};
  localparam logic [31:0] L1_HI = {22'h01234, 2'b11, 8'h03};
  localparam logic [31:0] L1_LO = {20'h00042, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 3'b000};

  task automatic t_reset();
    chk("R1 pointer after reset", 32'(repl_ptr), 32'h0);
    chk("R1 no response after reset", 32'(mm_rvalid), 32'h0);
    mm(1'b0, mka(4'h0, 6'd0), 2'b10, 1'b1, '0);
    chk("R1 entry 0 valid/dirty clear", rd & 32'h300, 32'h0);
    mm(1'b0, mka(4'h1, 6'd63), 2'b10, 1'b1, '0);
    chk("R1 entry 63 valid/dirty clear", rd & 32'h820, 32'h0);
  endtask

  task automatic t_load();
    repl_bound = 6'd63;
    do_load(L0_HI, L0_LO, 32'hFFFF_FFFD);
    chk("R3 pointer after first load", 32'(repl_ptr), 32'h1);
    mm(1'b0, mka(4'h0, 6'd0), 2'b10, 1'b1, '0);
    chk("R2 R5 tag view of loaded entry", rd, {22'h2ABCD, 1'b1, 1'b1, 8'h5A});
    mm(1'b0, mka(4'h1, 6'd0), 2'b10, 1'b1, '0);
    chk("R2 R6 frame view of loaded entry", rd, L0_LO);
    mm(1'b0, mka(4'h2, 6'd0), 2'b10, 1'b1, '0);
    chk("R2 R7 attribute view of loaded entry", rd, 32'hD);
    do_load(L1_HI, L1_LO, 32'h2);
    chk("R3 pointer after second load", 32'(repl_ptr), 32'h2);
    mm(1'b0, mka(4'h0, 6'd1), 2'b10, 1'b1, '0);
    chk("R2 R11 tag view of entry 1 ignores hi bits 9:8", rd, {22'h01234, 1'b0, 1'b1, 8'h03});
  endtask

  task automatic t_counter();
    repl_bound = 6'd2;
    set_ptr(6'd1);
    chk("R4 pointer written", 32'(repl_ptr), 32'h1);
    do_load({22'h00A01, 10'h0}, L0_LO, 32'h0);
    chk("R3 advance below bound", 32'(repl_ptr), 32'h2);
    do_load({22'h00A02, 10'h0}, L0_LO, 32'h0);
    chk("R3 wrap at bound", 32'(repl_ptr), 32'h0);
    mm(1'b0, mka(4'h0, 6'd2), 2'b10, 1'b1, '0);
    chk("R2 load landed in entry 2", 32'(rd[31:10]), 32'h00A02);
    set_ptr(6'd9);
    do_load({22'h00A09, 10'h0}, L0_LO, 32'h0);
    chk("R3 wrap from above bound", 32'(repl_ptr), 32'h0);
    mm(1'b0, mka(4'h0, 6'd9), 2'b10, 1'b1, '0);
    chk("R2 load landed in entry 9", 32'(rd[31:10]), 32'h00A09);
    // load and pointer write together
    @(negedge clk);
    ld_cmd = 1'b1; pt_hi = {22'h00BBB, 10'h0}; pt_lo = L0_LO; pt_attr = 32'h0;
    repl_we = 1'b1; repl_wval = 6'd7;
    @(negedge clk);
    ld_cmd = 1'b0; repl_we = 1'b0;
    chk("R4 write beats advance", 32'(repl_ptr), 32'h7);
    mm(1'b0, mka(4'h0, 6'd0), 2'b10, 1'b1, '0);
    chk("R4 load used old pointer", 32'(rd[31:10]), 32'h00BBB);
  endtask

  task automatic t_mm();
    mm(1'b1, mka(4'h0, 6'd20), 2'b10, 1'b1, {22'h15555, 1'b0, 1'b1, 8'hC3});
    chk("R12 write response valid", 32'(rv), 32'h1);
    chk("R12 write response data zero", rd, 32'h0);
    chk("R12 write response no error", 32'(er), 32'h0);
    mm(1'b0, mka(4'h0, 6'd20), 2'b10, 1'b1, '0);
    chk("R5 tag view write/read", rd, {22'h15555, 1'b0, 1'b1, 8'hC3});
    mm(1'b0, mka(4'h1, 6'd20), 2'b10, 1'b1, '0);
    chk("R8 tag-view valid seen in frame view", rd & 32'h820, 32'h800);
    mm(1'b1, mka(4'h1, 6'd20), 2'b10, 1'b1,
       {20'h12345, 1'b0, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 3'b111});
    mm(1'b0, mka(4'h1, 6'd20), 2'b10, 1'b1, '0);
    chk("R6 frame view write/read", rd, {20'h12345, 1'b0, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000});
    mm(1'b0, mka(4'h0, 6'd20), 2'b10, 1'b1, '0);
    chk("R8 frame-view valid/dirty seen in tag view", rd, {22'h15555, 1'b1, 1'b0, 8'hC3});
    mm(1'b1, mka(4'h2, 6'd20), 2'b10, 1'b1, 32'hFFFF_FFF6);
    mm(1'b0, mka(4'h2, 6'd20), 2'b10, 1'b1, '0);
    chk("R7 attribute view write/read", rd, 32'h6);
  endtask

  task automatic t_reject();
    localparam logic [31:0] E20 = {22'h15555, 1'b1, 1'b0, 8'hC3};
    mm(1'b1, mka(4'h0, 6'd20), 2'b01, 1'b1, 32'hFFFF_FFFF);
    chk("R9 narrow write flagged", 32'(er), 32'h1);
    mm(1'b0, mka(4'h0, 6'd20), 2'b10, 1'b1, '0);
    chk("R9 narrow write left entry", rd, E20);
    mm(1'b0, mka(4'h0, 6'd20), 2'b00, 1'b1, '0);
    chk("R9 narrow read flagged", 32'(er), 32'h1);
    chk("R9 narrow read returns zero", rd, 32'h0);
    mm(1'b1, mka(4'h0, 6'd20), 2'b10, 1'b0, 32'h0);
    chk("R10 user write flagged", 32'(er), 32'h1);
    mm(1'b0, mka(4'h0, 6'd20), 2'b10, 1'b0, '0);
    chk("R10 user read served", rd, E20);
    chk("R10 user read no error", 32'(er), 32'h0);
    mm(1'b0, mka(4'h3, 6'd20), 2'b10, 1'b1, '0);
    chk("R11 bad view flagged", 32'(er), 32'h1);
    chk("R11 bad view returns zero", rd, 32'h0);
    @(posedge clk); #1;
    chk("R12 no response without request", 32'(mm_rvalid), 32'h0);
  endtask

  task automatic t_collide();
    // pointer is 7, bound 2
    @(negedge clk);
    ld_cmd = 1'b1; pt_hi = {22'h3C3C3, 2'b00, 8'h77}; pt_lo = L1_LO; pt_attr = 32'h0;
    mm_req = 1'b1; mm_we = 1'b1; mm_priv = 1'b1; mm_size = 2'b10;
    mm_addr = mka(4'h0, 6'd30); mm_wdata = {22'h11111, 1'b1, 1'b1, 8'h11};
    @(posedge clk); #1;
    chk("R13 discarded write not flagged", 32'(mm_err), 32'h0);
    @(negedge clk);
    ld_cmd = 1'b0; mm_req = 1'b0; mm_we = 1'b0;
    chk("R3 wrap from pointer 7", 32'(repl_ptr), 32'h0);
    mm(1'b0, mka(4'h0, 6'd30), 2'b10, 1'b1, '0);
    chk("R13 entry 30 untouched", rd & 32'h300, 32'h0);
    mm(1'b0, mka(4'h0, 6'd7), 2'b10, 1'b1, '0);
    chk("R13 load performed", rd, {22'h3C3C3, 1'b0, 1'b1, 8'h77});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_counter();
    t_mm();
    t_reject();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule